// File: doc/BRIEF.md
# Sync-Gated Receive Bit Buffer with Serial Readout

This block sits behind a demodulator and takes one received bit per pulse of a bit-rate strobe. It holds back everything until a programmable synchronization word, of a programmable length, has appeared in the stream. Only the bits that follow the match are stored in a 16-bit buffer, so noise received before a frame never reaches the host. A fill-level interrupt tells the host when enough bits are waiting.

The host reads the buffer through an SPI slave port. The port runs in the system clock domain and oversamples the chip select, clock and data lines. Each transaction is framed by chip select low and lasts 16 serial clocks. The first data bit the host sends chooses between a buffer read and a status read. Raising chip select at any time returns the serial port to its idle state. Clearing either the receive enable or the buffer enable empties the buffer and restarts the synchronization search.

Top module: `sync_rx_fifo`

## Requirements
- R1: After reset, sdo and irq are 0. The first buffer read returns all zeros, and the first status read returns all zeros.
- R2: Bits that arrive before the synchronization match are discarded. The bit that completes the match is also discarded. Every later strobed bit is stored, in arrival order.
- R3: The match compares the most recent L received bits with the low L bits of syncWord. The value of L is syncLen, limited to the range 8 to 16: a value below 8 acts as 8, and a value above 16 acts as 16. No match is declared before L bits have been received since the last flush.
- R4: A buffer read is a transaction whose first SDI bit is 0. Slot k, for k from 0 to 15, is the value on sdo before the k-th rising SCK edge. Slot k carries the (k+1)-th oldest bit held when chip select fell, or 0 if fewer bits were held. Completing all 16 edges removes those bits from the buffer.
- R5: A status read is a transaction whose first SDI bit is 1. Slots 1 to 15 carry a 15-bit word, MSB first. Bit 14 is overflow, bit 13 is irq, bit 12 is the synchronized flag, and bits 11:7 are the stored bit count. The remaining bits are 0. A status read removes nothing.
- R6: If chip select rises before the 16th SCK edge, nothing is removed. The next transaction starts again from slot 0.
- R7: irq is 1 exactly when fillThr is nonzero and the stored bit count is at least fillThr.
- R8: A bit that arrives while 16 bits are already stored is dropped, and the overflow flag is set. The flag stays set until a buffer read completes.
- R9: While rxEn or fifoEn is 0, the buffer is empty and the overflow and synchronized flags are clear. Strobed bits are ignored. Once both enables are 1 again, the synchronization search starts afresh.
- R10: sdo is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEn | input | 1 | Receive path enable |
| fifoEn | input | 1 | Buffer enable |
| syncWord | input | 16 | Synchronization pattern, compared on its low L bits |
| syncLen | input | 5 | Pattern length, limited to the range 8 to 16 |
| fillThr | input | 5 | Interrupt fill threshold in bits; 0 disables the interrupt |
| rxBit | input | 1 | Demodulated receive bit |
| rxStrobe | input | 1 | One-cycle pulse marking a valid rxBit |
| csN | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI clock |
| sdi | input | 1 | SPI data from the host |
| sdo | output | 1 | SPI data to the host |
| irq | output | 1 | Fill-level interrupt |

## Verification
The assertions assume two things about the inputs. First, the configuration and enables change only while no transaction is open. Second, a buffer read never completes while the buffer is being flushed. The bench drives every SCK and chip select phase for eight system clocks, well beyond the synchronizer latency. It issues bit strobes and serial transactions in separate phases, so a push never coincides with a removal. It also changes the enables only while chip select is high.

// File: rtl/rxsync_pkg.sv
package rxsync_pkg;
  typedef struct packed {
    logic flush;  // receive path disabled: empty buffer, re-arm search
    logic snap;   // transaction opened: capture the read image
    logic pop;    // buffer read completed: remove captured bits
  } ctlStrobe_t;
endpackage

// File: rtl/rxsync_datapath.sv
module rxsync_datapath
  import rxsync_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SYNC_MIN = 8,
  parameter int SYNC_MAX = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LEN_W  = $clog2(SYNC_MAX + 1),
  localparam int STAT_W = DEPTH - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strb,
  input  logic                rxBit,
  input  logic                rxStrobe,
  input  logic [SYNC_MAX-1:0] syncWord,
  input  logic [LEN_W-1:0]    syncLen,
  input  logic [CNT_W-1:0]    fillThr,
  output logic [DEPTH-1:0]    fifoWord,
  output logic [STAT_W-1:0]   status,
  output logic                irq
);
  localparam int PAD = STAT_W - 3 - CNT_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [SYNC_MAX-1:0] syncSh, shNext, mask;
  logic [LEN_W-1:0]    seenCnt, seenNext, lenEff;
  logic                synced, matchNow, push, drop, ovf;
  logic [DEPTH-1:0]    fifoData;
  logic [CNT_W-1:0]    count, snapCnt, countNext;

  // Effective pattern length, limited to the legal range.
  always_comb begin
    if (syncLen < LEN_W'(SYNC_MIN))      lenEff = LEN_W'(SYNC_MIN);
    else if (syncLen > LEN_W'(SYNC_MAX)) lenEff = LEN_W'(SYNC_MAX);
    else                                 lenEff = syncLen;
    for (int i = 0; i < SYNC_MAX; i++) mask[i] = (i < int'(lenEff));
  end

  assign shNext   = {syncSh[SYNC_MAX-2:0], rxBit};
  assign seenNext = (seenCnt == LEN_W'(SYNC_MAX)) ? seenCnt : seenCnt + LEN_W'(1);
  assign matchNow = (seenNext >= lenEff) && (((shNext ^ syncWord) & mask) == '0);
  assign push     = rxStrobe && synced && (count != FULL);
  assign drop     = rxStrobe && synced && (count == FULL);
  assign countNext = count - (strb.pop ? snapCnt : '0) + {{(CNT_W-1){1'b0}}, push};

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      syncSh   <= '0;
      seenCnt  <= '0;
      synced   <= 1'b0;
      fifoData <= '0;
      count    <= '0;
      snapCnt  <= '0;
      ovf      <= 1'b0;
    end else begin
      if (rxStrobe && !synced) begin
        syncSh  <= shNext;
        seenCnt <= seenNext;
        if (matchNow) synced <= 1'b1;
      end
      if (push) fifoData <= {fifoData[DEPTH-2:0], rxBit};
      if (strb.snap) snapCnt <= count;
      count <= countNext;
      ovf   <= strb.pop ? drop : (ovf | drop);
    end
  end

  // Oldest held bit aligned to the MSB, unfilled slots zero.
  assign fifoWord = fifoData << (DEPTH - int'(count));
  assign irq      = (fillThr != '0) && (count >= fillThr);
  assign status   = {ovf, irq, synced, count, {PAD{1'b0}}};

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL);
  // R2
  nosync_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !synced |-> count == '0);
  // R8
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovf) |-> $past(count) == FULL);
  // R4
  pop_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.flush) |-> snapCnt <= count);
endmodule

// File: rtl/rxsync_ctrl.sv
module rxsync_ctrl
  import rxsync_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int STAT_W = DEPTH - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              fifoEn,
  input  logic              csN,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DEPTH-1:0]  fifoWord,
  input  logic [STAT_W-1:0] status,
  output ctlStrobe_t        strb,
  output logic              sdo
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(DEPTH);

  logic [1:0]       csMeta, sckMeta, sdiMeta;
  logic             csLowPrev, sckPrev, cmdStat;
  logic             csLow, csFall, sckRise;
  logic [CNT_W-1:0] bitCnt;
  logic [DEPTH-1:0] shiftReg;

  assign csLow   = !csMeta[1];
  assign csFall  = csLow && !csLowPrev;
  assign sckRise = csLow && sckMeta[1] && !sckPrev && (bitCnt != DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csMeta    <= 2'b11;
      sckMeta   <= '0;
      sdiMeta   <= '0;
      csLowPrev <= 1'b0;
      sckPrev   <= 1'b0;
      bitCnt    <= '0;
      cmdStat   <= 1'b0;
      shiftReg  <= '0;
    end else begin
      csMeta    <= {csMeta[0], csN};
      sckMeta   <= {sckMeta[0], sck};
      sdiMeta   <= {sdiMeta[0], sdi};
      csLowPrev <= csLow;
      sckPrev   <= sckMeta[1];
      if (!csLow) begin
        bitCnt   <= '0;
        cmdStat  <= 1'b0;
        shiftReg <= '0;
      end else if (csFall) begin
        bitCnt   <= '0;
        shiftReg <= fifoWord;
      end else if (sckRise) begin
        bitCnt <= bitCnt + CNT_W'(1);
        if (bitCnt == '0) begin
          cmdStat  <= sdiMeta[1];
          shiftReg <= sdiMeta[1] ? {status, 1'b0} : {shiftReg[DEPTH-2:0], 1'b0};
        end else begin
          shiftReg <= {shiftReg[DEPTH-2:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    strb.flush = !(rxEn && fifoEn);
    strb.snap  = csFall;
    strb.pop   = sckRise && (bitCnt == LAST) && !cmdStat;
  end

  assign sdo = csLow && shiftReg[DEPTH-1];

  // R6
  cs_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csLow |=> bitCnt == '0);
  // R4
  pop_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> bitCnt == DONE);
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo
  import rxsync_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SYNC_MIN = 8,
  parameter int SYNC_MAX = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LEN_W = $clog2(SYNC_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxEn,
  input  logic                fifoEn,
  input  logic [SYNC_MAX-1:0] syncWord,
  input  logic [LEN_W-1:0]    syncLen,
  input  logic [CNT_W-1:0]    fillThr,
  input  logic                rxBit,
  input  logic                rxStrobe,
  input  logic                csN,
  input  logic                sck,
  input  logic                sdi,
  output logic                sdo,
  output logic                irq
);
  ctlStrobe_t         strb;
  logic [DEPTH-1:0]   fifoWord;
  logic [DEPTH-2:0]   status;

  rxsync_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .fifoEn(fifoEn),
    .csN(csN), .sck(sck), .sdi(sdi),
    .fifoWord(fifoWord), .status(status), .strb(strb), .sdo(sdo)
  );

  rxsync_datapath #(.DEPTH(DEPTH), .SYNC_MIN(SYNC_MIN), .SYNC_MAX(SYNC_MAX)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rxBit(rxBit), .rxStrobe(rxStrobe),
    .syncWord(syncWord), .syncLen(syncLen), .fillThr(fillThr),
    .fifoWord(fifoWord), .status(status), .irq(irq)
  );
endmodule

// File: tb/tb_sync_rx_fifo.sv
module tb_sync_rx_fifo;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN, rxEn, fifoEn, rxBit, rxStrobe, csN, sck, sdi;
  logic [15:0] syncWord;
  logic [4:0]  syncLen, fillThr;
  wire sdo, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // independent model of the requirements
  logic [15:0] mSh;
  int mSeen, mCnt;
  bit mSync, mOvf;
  bit mq[16];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  sync_rx_fifo dut (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .fifoEn(fifoEn),
    .syncWord(syncWord), .syncLen(syncLen), .fillThr(fillThr),
    .rxBit(rxBit), .rxStrobe(rxStrobe), .csN(csN), .sck(sck), .sdi(sdi),
    .sdo(sdo), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int effLen();
    if (syncLen < 8) return 8;
    if (syncLen > 16) return 16;
    return int'(syncLen);
  endfunction

  function automatic bit expIrq();
    return (fillThr != 0) && (mCnt >= int'(fillThr));
  endfunction

  function automatic logic [15:0] expWord();
    logic [15:0] w = '0;
    for (int k = 0; k < 16; k++) if (k < mCnt) w[15-k] = mq[k];
    return w;
  endfunction

  function automatic logic [14:0] expStat();
    return {mOvf, expIrq(), mSync, 5'(mCnt), 7'b0};
  endfunction

  task automatic modelFlush();
    mSh = '0; mSeen = 0; mSync = 0; mCnt = 0; mOvf = 0;
  endtask

  task automatic modelBit(input bit b);
    logic [15:0] m;
    int len;
    if (!(rxEn && fifoEn)) return;
    if (!mSync) begin
      mSh = {mSh[14:0], b};
      if (mSeen < 16) mSeen++;
      len = effLen();
      m = '0;
      for (int i = 0; i < 16; i++) if (i < len) m[i] = 1'b1;
      if (mSeen >= len && ((mSh ^ syncWord) & m) == 16'h0) mSync = 1;
    end else if (mCnt == 16) begin
      mOvf = 1;
    end else begin
      mq[mCnt] = b;
      mCnt++;
    end
  endtask

  function automatic bit noiseBit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic sendBit(input bit b);
    @(negedge clk);
    rxBit = b; rxStrobe = 1'b1;
    @(negedge clk);
    rxStrobe = 1'b0;
    repeat (2) @(negedge clk);
    modelBit(b);
  endtask

  task automatic setEnables(input bit r, input bit f);
    @(negedge clk);
    rxEn = r; fifoEn = f;
    if (!(r && f)) modelFlush();
    repeat (2) @(negedge clk);
  endtask

  task automatic spiXfer(input bit cmd, input int nSlots, output logic [15:0] got);
    got = '0;
    @(negedge clk);
    check("R10 sdo idle", {31'b0, sdo}, 32'h0);
    csN = 1'b0; sdi = cmd;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < nSlots; k++) begin
      got[15-k] = sdo;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0; sdi = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    if (!cmd && nSlots == 16) begin
      mCnt = 0; mOvf = 0;
    end
  endtask

  task automatic readStatus(input string req);
    logic [15:0] g;
    spiXfer(1'b1, 16, g);
    check(req, {17'b0, g[14:0]}, {17'b0, expStat()});
  endtask

  task automatic readFifo(input string req);
    logic [15:0] g, e;
    e = expWord();
    spiXfer(1'b0, 16, g);
    check(req, {16'b0, g}, {16'b0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] g;
    int len, n;
    rstN = 0; rxEn = 0; fifoEn = 0; rxBit = 0; rxStrobe = 0;
    csN = 1; sck = 0; sdi = 0;
    syncWord = 16'h2DD4; syncLen = 5'd16; fillThr = 5'd0;
    modelFlush();
    repeat (6) @(negedge clk);
    check("R1 sdo reset", {31'b0, sdo}, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    rstN = 1;
    repeat (4) @(negedge clk);
    readStatus("R1 status after reset");
    readFifo("R1 read after reset");

    // sweep of lengths (including limited values) and payload sizes
    for (int ls = 6; ls <= 17; ls++) begin
      for (int pv = 0; pv < 4; pv++) begin
        syncLen  = 5'(ls);
        fillThr  = 5'((ls + pv * 5) % 18);
        syncWord = 16'hB38D ^ 16'(ls * 16'h02F1 + pv * 16'h0071);
        n = (pv == 0) ? 0 : (pv == 1) ? (ls % 7) + 2 : (pv == 2) ? 16 : 19;
        setEnables(1'b0, 1'b1);
        setEnables(1'b1, 1'b1);
        for (int i = 0; i < 12; i++) sendBit(noiseBit());
        len = effLen();
        for (int i = len - 1; i >= 0; i--) sendBit(syncWord[i]);
        for (int i = 0; i < n; i++) sendBit(noiseBit());
        check("R7 irq level", {31'b0, irq}, {31'b0, expIrq()});
        readStatus("R3 R5 R8 status before read");
        readFifo("R2 R3 R4 buffer read");
        readStatus("R4 R8 status after read");
        check("R7 irq after read", {31'b0, irq}, {31'b0, expIrq()});
      end
    end

    // aborted transaction leaves the buffer intact
    syncLen = 5'd8; syncWord = 16'h00C6; fillThr = 5'd3;
    setEnables(1'b0, 1'b1);
    setEnables(1'b1, 1'b1);
    for (int i = 7; i >= 0; i--) sendBit(syncWord[i]);
    sendBit(1); sendBit(0); sendBit(1); sendBit(1); sendBit(0);
    spiXfer(1'b0, 7, g);
    check("R6 abort partial slots", {16'b0, g[15:9]}, {16'b0, expWord() >> 9});
    readStatus("R6 status after abort");
    readFifo("R6 full read after abort");

    // disabled path ignores bits; enable drop empties the buffer
    setEnables(1'b1, 1'b0);
    for (int i = 7; i >= 0; i--) sendBit(syncWord[i]);
    sendBit(1); sendBit(1);
    setEnables(1'b1, 1'b1);
    readStatus("R9 status after disabled bits");
    for (int i = 7; i >= 0; i--) sendBit(syncWord[i]);
    sendBit(1); sendBit(0); sendBit(1); sendBit(1);
    check("R7 irq before drop", {31'b0, irq}, 32'h1);
    setEnables(1'b0, 1'b1);
    check("R9 irq after rx drop", {31'b0, irq}, 32'h0);
    setEnables(1'b1, 1'b1);
    readStatus("R9 status after rx drop");
    readFifo("R9 read after rx drop");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule